// File: doc/BRIEF.md
# Quad D Register with Merged Clocks

Four single-bit storage lanes sit side by side, each with its own data input. Every lane has two clock sources: a shared clock that goes to all lanes and a lane clock of its own. The two are ORed, so a lane stores its data on the rising edge of that combined signal. Holding the shared clock low and pulsing one lane clock updates that lane alone. Holding every lane clock low and pulsing the shared clock updates all four lanes at once.

A single set line forces every lane high at once, with no clock involved. Each lane also has its own clear line that forces only that lane low, again with no clock. When set and clear are active on the same lane together, clear wins, and the attached checker treats that overlap as illegal while the lane's combined clock is active. Each lane drives a true output and an inverted output. Every input models a signal whose open state reads low, so if the inputs are all low the clocks stay idle and the stored state does not move.

Top module: `quad_reg_orclk`

## Requirements
- R1: The block holds LANES (default 4) independent lanes, and lane i stores only its own data bit din[i].
- R2: Lane i loads din[i] into q[i] on every rising edge of (clk_shared OR clk_lane[i]).
- R3: With clk_shared held low, a pulse on clk_lane[i] updates q[i] and leaves every other lane's q unchanged.
- R4: With every clk_lane bit held low, a pulse on clk_shared updates all lanes together.
- R5: When set_all is high, every lane whose clear is low reads q = 1 at once, with no clock edge. The value stays after set_all falls.
- R6: When clr[i] is high, q[i] reads 0 at once, with no clock edge, and the other lanes do not change.
- R7: When set_all and clr[i] are both high, q[i] is 0. The checker flags the overlap if it is present when the lane's combined clock falls.
- R8: A rising edge on one clock source while the other source of the same lane is already high causes no new load. A data change while the combined clock is high does not reach q either.
- R9: q_n[i] is always the inverse of q[i].
- R10: While all clock, set and clear inputs are low (their open state), a data change leaves q unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_shared | input | 1 | Clock shared by all lanes |
| clk_lane | input | LANES | Clock of each lane, ORed with clk_shared |
| din | input | LANES | Data of each lane |
| set_all | input | 1 | Asynchronous set of all lanes, active high |
| clr | input | LANES | Asynchronous clear of each lane, active high |
| q | output | LANES | True output of each lane |
| q_n | output | LANES | Inverted output of each lane |

## Verification
The checker samples on the falling edge of each lane's combined clock. It assumes that set_all and clr never change at the same instant as that falling edge, and that a set/clear overlap on a lane never lasts across such an edge. The bench changes every input on a grid that never lines up with a clock fall caused by the same step. It applies the set/clear overlap only while all clocks rest low. It releases set_all before clear, so no lane has to reassert its set after clear drops. It also never changes data and raises a clock in the same step.

// File: rtl/qreg_pkg.sv
package qreg_pkg;
  localparam int unsigned QREG_LANES = 4;

  // value a lane takes under each asynchronous control
  localparam logic QREG_CLR_VAL = 1'b0;
  localparam logic QREG_SET_VAL = 1'b1;
endpackage

// File: rtl/qreg_clk_merge.sv
module qreg_clk_merge #(
  parameter int unsigned LANES = qreg_pkg::QREG_LANES
) (
  input  logic             shared_ck,
  input  logic [LANES-1:0] lane_ck,
  output logic [LANES-1:0] eff_ck
);
  // plain OR per lane, no further gating
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_or
      assign eff_ck[g] = shared_ck | lane_ck[g];
    end
  endgenerate
endmodule

// File: rtl/qreg_cell.sv
module qreg_cell (
  input  logic ck,
  input  logic d,
  input  logic set_a,
  input  logic clr_a,
  output logic q
);
  import qreg_pkg::*;

  logic q_nxt;

  always_comb begin
    q_nxt = d;
  end

  // clear has priority over set
  always_ff @(posedge ck or posedge clr_a or posedge set_a) begin
    if (clr_a)      q <= QREG_CLR_VAL;
    else if (set_a) q <= QREG_SET_VAL;
    else            q <= q_nxt;
  end
endmodule

// File: rtl/qreg_out_drv.sv
module qreg_out_drv #(
  parameter int unsigned LANES = qreg_pkg::QREG_LANES
) (
  input  logic [LANES-1:0] st,
  output logic [LANES-1:0] q_t,
  output logic [LANES-1:0] q_c
);
  always_comb begin
    q_t = st;
    q_c = ~st;
  end
endmodule

// File: rtl/quad_reg_orclk.sv
module quad_reg_orclk #(
  parameter int unsigned LANES = qreg_pkg::QREG_LANES
) (
  input  logic             clk_shared,
  input  logic [LANES-1:0] clk_lane,
  input  logic [LANES-1:0] din,
  input  logic             set_all,
  input  logic [LANES-1:0] clr,
  output logic [LANES-1:0] q,
  output logic [LANES-1:0] q_n
);
  logic [LANES-1:0] eff_ck;
  logic [LANES-1:0] lane_st;

  qreg_clk_merge #(.LANES(LANES)) u_merge (
    .shared_ck (clk_shared),
    .lane_ck   (clk_lane),
    .eff_ck    (eff_ck)
  );

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      qreg_cell u_cell (
        .ck    (eff_ck[g]),
        .d     (din[g]),
        .set_a (set_all),
        .clr_a (clr[g]),
        .q     (lane_st[g])
      );
    end
  endgenerate

  qreg_out_drv #(.LANES(LANES)) u_out (
    .st  (lane_st),
    .q_t (q),
    .q_c (q_n)
  );
endmodule

// File: rtl/qreg_chk.sv
module qreg_chk #(
  parameter int unsigned LANES = qreg_pkg::QREG_LANES
) (
  input logic [LANES-1:0] eff_ck,
  input logic             set_all,
  input logic [LANES-1:0] clr,
  input logic [LANES-1:0] q,
  input logic [LANES-1:0] q_n
);
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_chk
      // R5: set holds the lane high whenever its clear is low
      a_r5_set_high: assert property (@(negedge eff_ck[g])
        (set_all && !clr[g]) |-> q[g]);
      // R6: clear holds the lane low
      a_r6_clr_low: assert property (@(negedge eff_ck[g])
        clr[g] |-> !q[g]);
      // R7: set and clear overlapping on a clocked lane is flagged
      a_r7_no_overlap: assert property (@(negedge eff_ck[g])
        !(set_all && clr[g]));
      // R9: outputs stay complementary
      a_r9_complement: assert property (@(negedge eff_ck[g])
        q_n[g] == !q[g]);
    end
  endgenerate
endmodule

bind quad_reg_orclk qreg_chk #(.LANES(LANES)) u_chk (
  .eff_ck  (eff_ck),
  .set_all (set_all),
  .clr     (clr),
  .q       (q),
  .q_n     (q_n)
);

// File: tb/test_quad_reg_orclk.sv
module test_quad_reg_orclk;
  localparam int N = 4;

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } item_t;

  logic         tb_clk = 1'b0;
  logic         clk_shared = 1'b0;
  logic [N-1:0] clk_lane = '0;
  logic [N-1:0] din = '0;
  logic         set_all = 1'b0;
  logic [N-1:0] clr = '0;
  logic [N-1:0] q, q_n;

  item_t        sb[$];
  logic [N-1:0] model = '0;
  logic [N-1:0] eff_prev = '0;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           done = 0;

  always #2 tb_clk = ~tb_clk; // 250 MHz

  quad_reg_orclk #(.LANES(N)) i_quad_reg_orclk (
    .clk_shared (clk_shared),
    .clk_lane   (clk_lane),
    .din        (din),
    .set_all    (set_all),
    .clr        (clr),
    .q          (q),
    .q_n        (q_n)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // driver: apply one input vector, update the requirement model, queue the expectation
  task automatic step(input logic sh, input logic [N-1:0] ln, input logic [N-1:0] dd,
                      input logic st, input logic [N-1:0] cl, input string tag);
    logic [N-1:0] eff_new;
    logic [N-1:0] rise;
    item_t it;
    @(posedge tb_clk);
    din = dd; set_all = st; clr = cl; clk_lane = ln; clk_shared = sh;
    eff_new = {N{sh}} | ln;
    rise = eff_new & ~eff_prev;
    for (int i = 0; i < N; i++) begin
      if (cl[i])        model[i] = 1'b0;
      else if (st)      model[i] = 1'b1;
      else if (rise[i]) model[i] = dd[i];
    end
    eff_prev = eff_new;
    it.exp = model;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compare away from the driving edge
  initial begin
    forever begin
      @(negedge tb_clk);
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        n_chk++;
        if (q !== it.exp) begin
          n_fail++;
          $display("FAIL %s: q=%b expected %b", it.tag, q, it.exp);
        end
        n_chk++;
        if (q_n !== ~it.exp) begin
          n_fail++;
          $display("FAIL R9 (%s): q_n=%b expected %b", it.tag, q_n, ~it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge tb_clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
    end
  end

  initial begin
    //    sh  lanes    data     set  clr
    step(0, 4'b0000, 4'b0000, 0, 4'b1111, "R6 reset state");
    step(0, 4'b0000, 4'b1111, 0, 4'b0000, "R10 data idle");
    step(0, 4'b0100, 4'b1111, 0, 4'b0000, "R3 lane2 alone");
    step(0, 4'b0000, 4'b1111, 0, 4'b0000, "R3 lane2 low");
    step(0, 4'b0000, 4'b1010, 0, 4'b0000, "R10 data idle");
    step(1, 4'b0000, 4'b1010, 0, 4'b0000, "R4 shared edge");
    step(0, 4'b0000, 4'b0101, 0, 4'b0000, "R10 data idle");
    step(0, 4'b0001, 4'b0101, 0, 4'b0000, "R2 lane0 edge");
    step(0, 4'b0001, 4'b0100, 0, 4'b0000, "R8 data while high");
    step(1, 4'b0001, 4'b0100, 0, 4'b0000, "R8 shared over lane0");
    step(0, 4'b0000, 4'b0100, 0, 4'b0000, "R8 clocks low");
    step(0, 4'b0000, 4'b1111, 0, 4'b0000, "R10 data idle");
    step(1, 4'b0000, 4'b1111, 0, 4'b0000, "R4 shared edge");
    step(1, 4'b0000, 4'b0000, 0, 4'b0000, "R8 data while high");
    step(1, 4'b0010, 4'b0000, 0, 4'b0000, "R8 lane1 over shared");
    step(0, 4'b0000, 4'b0000, 0, 4'b0000, "R8 clocks low");
    step(0, 4'b0000, 4'b0000, 0, 4'b1111, "R6 clear all");
    step(0, 4'b0000, 4'b0000, 0, 4'b0000, "R6 release");
    step(0, 4'b0000, 4'b0000, 1, 4'b0000, "R5 set");
    step(0, 4'b0000, 4'b0000, 0, 4'b0000, "R5 set released");
    step(0, 4'b0000, 4'b0000, 0, 4'b1000, "R6 clear lane3");
    step(0, 4'b0000, 4'b0000, 0, 4'b0000, "R6 release");
    step(0, 4'b0000, 4'b0000, 1, 4'b0010, "R7 clear beats set");
    step(0, 4'b0000, 4'b0000, 0, 4'b0010, "R7 set dropped");
    step(0, 4'b0000, 4'b0000, 0, 4'b0000, "R7 clear dropped");
    step(0, 4'b1000, 4'b0000, 0, 4'b0000, "R1 lane3 own data");
    step(0, 4'b0000, 4'b0000, 0, 4'b0000, "R1 lane3 low");
    repeat (3) @(posedge tb_clk);
    done = 1;
    finish_run();
  end
endmodule